// File: doc/BRIEF.md
# Clock Mode Loss-of-Clock Supervisor

This block watches over a clock generator that runs in one of four modes: self-clocked, FLL engaged with the internal reference, FLL bypassed onto the external reference, and FLL engaged with the external reference. For each mode it decides which clocks are supervised: the external reference, the oscillator clock, both, or neither. Separate frequency detectors outside the block send single-cycle loss pulses. The block keeps only the pulses for clocks it is currently supervising.

A loss that is kept sets a sticky loss-of-clock flag. In the two FLL-engaged modes it also sets a loss-of-lock flag. When the failing clock is one the current mode depends on, the block drops to a safer mode. It writes the new mode into both the requested-mode field and the active-mode status field. The sticky flags then drive either an interrupt or a reset request. Software clears the flags in two steps: a status read strobe, then a later write of 1 to the flag bit.

Software picks a mode by writing the requested-mode field. The active-mode field follows one cycle later. The block never moves itself back to a higher mode.

Top module: `lossclk_supervisor`

## Requirements
- R1: After synchronous reset, the requested and active mode fields are 00 (self-clocked). The loss-of-clock flag, loss-of-lock flag, interrupt and reset request are all 0.
- R2: A mode write (`sw_wr`=1 with `sw_mode`) updates `mode_req` at the clock edge that samples it. `mode_act` takes the same value one edge later. Encoding: 00 self-clocked, 01 FLL engaged internal, 10 FLL bypassed external, 11 FLL engaged external.
- R3: Monitoring enables depend on `mode_act`:
  - 00: the reference is monitored.
  - 01: the oscillator is monitored and the reference is not.
  - 10: the reference is monitored only while `ref_valid`=1, and the oscillator is not.
  - 11: both are monitored.
- R4: In mode 00 entered from mode 10 or out of reset, the oscillator is not monitored until `osc_stable` has been 1. From then on it stays monitored while in mode 00. Mode 00 entered from 01 or 11 monitors the oscillator at once.
- R5: While `detect_disable`=1 or `gen_off`=1, neither clock is monitored. Loss pulses then change no flag and no mode.
- R6: In mode 11:
  - A monitored reference loss with `ref_valid`=0 moves to mode 00.
  - A monitored reference loss with `ref_valid`=1 moves to mode 10.
  - A monitored oscillator loss moves to mode 10.
- R7: In mode 10, a monitored reference loss moves to mode 00. A loss in mode 00 or 01 sets the flag but leaves the mode unchanged.
- R8: A fallback writes the new mode into `mode_req` and `mode_act` at the same edge that samples the loss. It overrides a mode write in the same cycle.
- R9: `loss_stat` sets at the edge sampling a monitored loss and holds. When `loc_reset_en`=0 it clears only at an edge with `flag_wr`=1 and `flag_wdata`=1, after a `stat_rd` at an earlier edge while a flag was set. A write without a prior read does not clear it, and neither does a write of 0.
- R10: With `loc_reset_en`=1, a set loss flag drives `rst_req`=1 and `irq`=0. The read-then-write acknowledge has no effect, and only reset clears the flag.
- R11: A monitored loss in mode 01 or 11 also sets `lock_stat`. A loss in mode 00 or 10 does not. With `lol_reset_en`=1 and `lock_stat`=1, `rst_req` is 1 and `irq` is 0, even when `loc_reset_en`=0. `lock_stat` clears with the same acknowledge as `loss_stat`.
- R12: A loss pulse for a clock that is not monitored in the current mode changes no flag and no mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr | input | 1 | Mode write strobe |
| sw_mode | input | 2 | Mode written by software |
| gen_off | input | 1 | Clock generator is off |
| detect_disable | input | 1 | Master disable for all loss detection |
| ref_valid | input | 1 | External reference meets its minimum frequency |
| osc_stable | input | 1 | Oscillator clock is stable |
| ref_loss | input | 1 | Reference loss pulse from its detector |
| osc_loss | input | 1 | Oscillator loss pulse from its detector |
| stat_rd | input | 1 | Status register read strobe |
| flag_wr | input | 1 | Interrupt flag write strobe |
| flag_wdata | input | 1 | Value written to the interrupt flag |
| loc_reset_en | input | 1 | Loss of clock requests reset instead of interrupt |
| lol_reset_en | input | 1 | Loss of lock requests reset |
| mode_req | output | 2 | Requested mode field |
| mode_act | output | 2 | Active mode status field |
| loss_stat | output | 1 | Sticky loss-of-clock flag |
| lock_stat | output | 1 | Sticky loss-of-lock flag |
| ref_mon | output | 1 | Reference is currently monitored |
| osc_mon | output | 1 | Oscillator is currently monitored |
| irq | output | 1 | Loss interrupt |
| rst_req | output | 1 | Loss reset request |

## Verification
The monitor enables are combinational from the registered mode and the level inputs, so they are checked in the same cycle the levels are applied. A loss pulse sampled at an edge shows up in the flags, the interrupt or reset request, and both mode fields right after that edge. A mode write shows up in `mode_req` after one edge and in `mode_act` after two. The bench drives every input on the falling edge and holds each strobe for exactly one rising edge. It reads results at the next falling edge, or one cycle later for the active mode after a write, so each check lands in the cycle its result is due.

// File: rtl/lossclk_pkg.sv
package lossclk_pkg;

    localparam int MODE_W    = 2;
    localparam int NUM_FLAGS = 2;
    localparam int FLAG_LOC  = 0;
    localparam int FLAG_LOL  = 1;

    typedef enum logic [MODE_W-1:0] {
        M_SELF = 2'b00,
        M_FEI  = 2'b01,
        M_BYP  = 2'b10,
        M_FEE  = 2'b11
    } clk_mode_e;

    typedef struct packed {
        logic ref_on;
        logic osc_on;
    } mon_t;

    typedef struct packed {
        logic ref_evt;
        logic osc_evt;
    } evt_t;

    function automatic logic is_engaged(clk_mode_e m);
        return (m == M_FEI) || (m == M_FEE);
    endfunction

    function automatic clk_mode_e fallback_mode(clk_mode_e cur, evt_t e, logic ref_ok);
        clk_mode_e nxt;
        nxt = cur;
        case (cur)
            M_FEE: begin
                if (e.ref_evt && !ref_ok)
                    nxt = M_SELF;
                else if (e.ref_evt || e.osc_evt)
                    nxt = M_BYP;
            end
            M_BYP: begin
                if (e.ref_evt)
                    nxt = M_SELF;
            end
            default: nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/lossclk_monsel.sv
module lossclk_monsel
    import lossclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  clk_mode_e act,
    input  logic      gen_off,
    input  logic      detect_disable,
    input  logic      ref_valid,
    input  logic      osc_stable,
    input  logic      ref_loss,
    input  logic      osc_loss,
    output mon_t      mon,
    output evt_t      evt
);

    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst || gen_off)
            armed_q <= 1'b0;
        else if (act != M_SELF)
            armed_q <= (act != M_BYP);
        else if (osc_stable)
            armed_q <= 1'b1;
    end

    always_comb begin
        mon = '0;
        if (!gen_off && !detect_disable) begin
            case (act)
                M_SELF: begin mon.ref_on = 1'b1;      mon.osc_on = armed_q | osc_stable; end
                M_FEI:  begin mon.ref_on = 1'b0;      mon.osc_on = 1'b1; end
                M_BYP:  begin mon.ref_on = ref_valid; mon.osc_on = 1'b0; end
                default: begin mon.ref_on = 1'b1;     mon.osc_on = 1'b1; end
            endcase
        end
        evt.ref_evt = ref_loss & mon.ref_on;
        evt.osc_evt = osc_loss & mon.osc_on;
    end

endmodule

// File: rtl/lossclk_modectl.sv
module lossclk_modectl
    import lossclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_wr,
    input  logic [MODE_W-1:0] sw_mode,
    input  evt_t              evt,
    input  logic              ref_valid,
    output clk_mode_e         req,
    output clk_mode_e         act
);

    clk_mode_e fb;
    logic      fb_take;

    always_comb begin
        fb      = fallback_mode(act, evt, ref_valid);
        fb_take = (fb != act);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= M_SELF;
            act <= M_SELF;
        end else if (fb_take) begin
            req <= fb;
            act <= fb;
        end else begin
            if (sw_wr)
                req <= clk_mode_e'(sw_mode);
            act <= req;
        end
    end

endmodule

// File: rtl/lossclk_flags.sv
module lossclk_flags
    import lossclk_pkg::*;
#(
    parameter int N = NUM_FLAGS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic         stat_rd,
    input  logic         flag_wr,
    input  logic         flag_wdata,
    input  logic         loc_reset_en,
    input  logic         lol_reset_en,
    output logic [N-1:0] flags,
    output logic         irq,
    output logic         rst_req
);

    logic rd_seen_q;
    logic ack_fire;

    assign ack_fire = flag_wr & flag_wdata & rd_seen_q & ~loc_reset_en;

    always_ff @(posedge clk) begin
        if (rst)
            rd_seen_q <= 1'b0;
        else if (ack_fire)
            rd_seen_q <= 1'b0;
        else if (stat_rd && (|flags))
            rd_seen_q <= 1'b1;
        else if (~|flags)
            rd_seen_q <= 1'b0;
    end

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (set_vec[i])
                flags[i] <= 1'b1;
            else if (ack_fire)
                flags[i] <= 1'b0;
        end
    end

    always_comb begin
        rst_req = (flags[FLAG_LOC] & loc_reset_en) | (flags[FLAG_LOL] & lol_reset_en);
        irq     = flags[FLAG_LOC] & ~loc_reset_en & ~(flags[FLAG_LOL] & lol_reset_en);
    end

endmodule

// File: rtl/lossclk_supervisor.sv
module lossclk_supervisor
    import lossclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_wr,
    input  logic [MODE_W-1:0] sw_mode,
    input  logic              gen_off,
    input  logic              detect_disable,
    input  logic              ref_valid,
    input  logic              osc_stable,
    input  logic              ref_loss,
    input  logic              osc_loss,
    input  logic              stat_rd,
    input  logic              flag_wr,
    input  logic              flag_wdata,
    input  logic              loc_reset_en,
    input  logic              lol_reset_en,
    output logic [MODE_W-1:0] mode_req,
    output logic [MODE_W-1:0] mode_act,
    output logic              loss_stat,
    output logic              lock_stat,
    output logic              ref_mon,
    output logic              osc_mon,
    output logic              irq,
    output logic              rst_req
);

    clk_mode_e            req_m;
    clk_mode_e            act_m;
    mon_t                 mon;
    evt_t                 evt;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] flags;

    lossclk_monsel u_monsel (
        .clk            (clk),
        .rst            (rst),
        .act            (act_m),
        .gen_off        (gen_off),
        .detect_disable (detect_disable),
        .ref_valid      (ref_valid),
        .osc_stable     (osc_stable),
        .ref_loss       (ref_loss),
        .osc_loss       (osc_loss),
        .mon            (mon),
        .evt            (evt)
    );

    lossclk_modectl u_modectl (
        .clk       (clk),
        .rst       (rst),
        .sw_wr     (sw_wr),
        .sw_mode   (sw_mode),
        .evt       (evt),
        .ref_valid (ref_valid),
        .req       (req_m),
        .act       (act_m)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[FLAG_LOC] = evt.ref_evt | evt.osc_evt;
        set_vec[FLAG_LOL] = (evt.ref_evt | evt.osc_evt) & is_engaged(act_m);
    end

    lossclk_flags #(.N(NUM_FLAGS)) u_flags (
        .clk          (clk),
        .rst          (rst),
        .set_vec      (set_vec),
        .stat_rd      (stat_rd),
        .flag_wr      (flag_wr),
        .flag_wdata   (flag_wdata),
        .loc_reset_en (loc_reset_en),
        .lol_reset_en (lol_reset_en),
        .flags        (flags),
        .irq          (irq),
        .rst_req      (rst_req)
    );

    assign mode_req  = req_m;
    assign mode_act  = act_m;
    assign loss_stat = flags[FLAG_LOC];
    assign lock_stat = flags[FLAG_LOL];
    assign ref_mon   = mon.ref_on;
    assign osc_mon   = mon.osc_on;

endmodule

// File: rtl/lossclk_supervisor_chk.sv
module lossclk_supervisor_chk (
    input logic       clk,
    input logic       rst,
    input logic       sw_wr,
    input logic       gen_off,
    input logic       detect_disable,
    input logic       ref_valid,
    input logic       ref_loss,
    input logic       osc_loss,
    input logic       flag_wr,
    input logic       loc_reset_en,
    input logic [1:0] mode_req,
    input logic [1:0] mode_act,
    input logic       loss_stat,
    input logic       ref_mon,
    input logic       osc_mon,
    input logic       irq,
    input logic       rst_req
);

    AST_FEI_MONITOR_SET: assert property (@(posedge clk) disable iff (rst)
        (mode_act == 2'b01 && !detect_disable && !gen_off) |-> (!ref_mon && osc_mon)); // R3

    AST_DISABLE_NO_MONITOR: assert property (@(posedge clk) disable iff (rst)
        (detect_disable || gen_off) |-> (!ref_mon && !osc_mon)); // R5

    AST_FEE_OSC_TO_BYP: assert property (@(posedge clk) disable iff (rst)
        (mode_act == 2'b11 && osc_loss && osc_mon && !(ref_loss && ref_mon && !ref_valid))
        |=> (mode_act == 2'b10 && mode_req == 2'b10)); // R6

    AST_BYP_REF_TO_SELF: assert property (@(posedge clk) disable iff (rst)
        (mode_act == 2'b10 && ref_loss && ref_mon) |=> (mode_act == 2'b00 && mode_req == 2'b00)); // R7

    AST_SELF_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (mode_act == 2'b00 && mode_req == 2'b00 && !sw_wr) |=> (mode_act == 2'b00)); // R7

    AST_LOSS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (loss_stat && !flag_wr) |=> loss_stat); // R9

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> loss_stat); // R9

    AST_IRQ_RST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(irq && rst_req)); // R10

    AST_RESET_MODE_HOLDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (loss_stat && loc_reset_en) |=> loss_stat); // R10

    AST_UNMONITORED_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!loss_stat && !(ref_loss && ref_mon) && !(osc_loss && osc_mon)) |=> !loss_stat); // R12

endmodule

bind lossclk_supervisor lossclk_supervisor_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .sw_wr          (sw_wr),
    .gen_off        (gen_off),
    .detect_disable (detect_disable),
    .ref_valid      (ref_valid),
    .ref_loss       (ref_loss),
    .osc_loss       (osc_loss),
    .flag_wr        (flag_wr),
    .loc_reset_en   (loc_reset_en),
    .mode_req       (mode_req),
    .mode_act       (mode_act),
    .loss_stat      (loss_stat),
    .ref_mon        (ref_mon),
    .osc_mon        (osc_mon),
    .irq            (irq),
    .rst_req        (rst_req)
);

// File: tb/test_lossclk_supervisor.sv
`timescale 1ns/1ps
module test_lossclk_supervisor;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sw_wr = 1'b0;
    logic [1:0] sw_mode = 2'b00;
    logic       gen_off = 1'b0;
    logic       detect_disable = 1'b0;
    logic       ref_valid = 1'b0;
    logic       osc_stable = 1'b0;
    logic       ref_loss = 1'b0;
    logic       osc_loss = 1'b0;
    logic       stat_rd = 1'b0;
    logic       flag_wr = 1'b0;
    logic       flag_wdata = 1'b0;
    logic       loc_reset_en = 1'b0;
    logic       lol_reset_en = 1'b0;
    logic [1:0] mode_req;
    logic [1:0] mode_act;
    logic       loss_stat;
    logic       lock_stat;
    logic       ref_mon;
    logic       osc_mon;
    logic       irq;
    logic       rst_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    lossclk_supervisor i_lossclk_supervisor (
        .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_mode(sw_mode), .gen_off(gen_off),
        .detect_disable(detect_disable), .ref_valid(ref_valid), .osc_stable(osc_stable),
        .ref_loss(ref_loss), .osc_loss(osc_loss), .stat_rd(stat_rd), .flag_wr(flag_wr),
        .flag_wdata(flag_wdata), .loc_reset_en(loc_reset_en), .lol_reset_en(lol_reset_en),
        .mode_req(mode_req), .mode_act(mode_act), .loss_stat(loss_stat), .lock_stat(lock_stat),
        .ref_mon(ref_mon), .osc_mon(osc_mon), .irq(irq), .rst_req(rst_req)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        tick();
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk) begin sw_wr = 1'b1; sw_mode = m; end
        @(negedge clk) sw_wr = 1'b0;
        tick();
    endtask

    task automatic pulse_loss(input logic r, input logic o);
        @(negedge clk) begin ref_loss = r; osc_loss = o; end
        @(negedge clk) begin ref_loss = 1'b0; osc_loss = 1'b0; end
    endtask

    task automatic ack();
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) begin stat_rd = 1'b0; flag_wr = 1'b1; flag_wdata = 1'b1; end
        @(negedge clk) begin flag_wr = 1'b0; flag_wdata = 1'b0; end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 mode_req", {2'b0, mode_req}, 4'h0);
        chk("R1 mode_act", {2'b0, mode_act}, 4'h0);
        chk("R1 flags/irq/rst_req", {loss_stat, lock_stat, irq, rst_req}, 4'h0);
        chk("R3 self ref_mon", {3'b0, ref_mon}, 4'h1);
        chk("R4 self osc_mon before stable", {3'b0, osc_mon}, 4'h0);
    endtask

    task automatic t_mode_write();
        @(negedge clk) begin sw_wr = 1'b1; sw_mode = 2'b11; end
        @(negedge clk) sw_wr = 1'b0;
        chk("R2 req after one edge", {2'b0, mode_req}, 4'h3);
        chk("R2 act lags", {2'b0, mode_act}, 4'h0);
        tick();
        chk("R2 act after two edges", {2'b0, mode_act}, 4'h3);
        ref_valid = 1'b0;
        #1 chk("R3 fee mon ref_valid=0", {2'b0, ref_mon, osc_mon}, 4'h3);
    endtask

    task automatic t_fee_osc();
        ref_valid = 1'b1;
        pulse_loss(1'b0, 1'b1);
        chk("R6 fee osc loss -> byp", {mode_req, mode_act}, 4'hA);
        chk("R11 flags and irq", {loss_stat, lock_stat, irq, rst_req}, 4'hE);
        chk("R3 byp mon valid", {2'b0, ref_mon, osc_mon}, 4'h2);
        ref_valid = 1'b0;
        #1 chk("R3 byp mon invalid", {2'b0, ref_mon, osc_mon}, 4'h0);
        @(negedge clk) begin flag_wr = 1'b1; flag_wdata = 1'b1; end
        @(negedge clk) flag_wr = 1'b0;
        chk("R9 write without read keeps flag", {3'b0, loss_stat}, 4'h1);
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) begin stat_rd = 1'b0; flag_wr = 1'b1; flag_wdata = 1'b0; end
        @(negedge clk) flag_wr = 1'b0;
        chk("R9 write zero keeps flag", {3'b0, loss_stat}, 4'h1);
        ack();
        chk("R9 ack clears", {loss_stat, lock_stat, irq, rst_req}, 4'h0);
    endtask

    task automatic t_byp_ref();
        ref_valid = 1'b1;
        pulse_loss(1'b1, 1'b0);
        chk("R7 byp ref loss -> self", {mode_req, mode_act}, 4'h0);
        chk("R11 no lock loss in byp", {loss_stat, lock_stat, irq, rst_req}, 4'hA);
        ack();
        chk("R4 self from byp osc unmonitored", {3'b0, osc_mon}, 4'h0);
        pulse_loss(1'b0, 1'b1);
        chk("R12 unmonitored osc loss ignored", {loss_stat, mode_act, 1'b0}, 4'h0);
        @(negedge clk) osc_stable = 1'b1;
        @(negedge clk) osc_stable = 1'b0;
        chk("R4 osc monitored after stable", {3'b0, osc_mon}, 4'h1);
        pulse_loss(1'b1, 1'b0);
        chk("R7 self loss keeps mode", {loss_stat, mode_act, lock_stat}, 4'h8);
        ack();
    endtask

    task automatic t_fee_ref();
        set_mode(2'b11);
        ref_valid = 1'b0;
        pulse_loss(1'b1, 1'b0);
        chk("R6 fee ref loss invalid -> self", {mode_req, mode_act}, 4'h0);
        ack();
        set_mode(2'b11);
        ref_valid = 1'b1;
        pulse_loss(1'b1, 1'b0);
        chk("R6 fee ref loss valid -> byp", {mode_req, mode_act}, 4'hA);
        ack();
    endtask

    task automatic t_disable();
        set_mode(2'b11);
        detect_disable = 1'b1;
        #1 chk("R5 disable mon off", {2'b0, ref_mon, osc_mon}, 4'h0);
        pulse_loss(1'b1, 1'b1);
        chk("R5 disable no effect", {loss_stat, 1'b0, mode_act}, 4'h3);
        detect_disable = 1'b0;
        gen_off = 1'b1;
        pulse_loss(1'b1, 1'b1);
        chk("R5 gen_off no effect", {loss_stat, 1'b0, mode_act}, 4'h3);
        gen_off = 1'b0;
    endtask

    task automatic t_fb_vs_write();
        @(negedge clk) begin sw_wr = 1'b1; sw_mode = 2'b01; osc_loss = 1'b1; end
        @(negedge clk) begin sw_wr = 1'b0; osc_loss = 1'b0; end
        chk("R8 fallback beats write", {mode_req, mode_act}, 4'hA);
        tick();
        chk("R8 act stays byp", {2'b0, mode_act}, 4'h2);
        ack();
    endtask

    task automatic t_fei();
        lol_reset_en = 1'b1;
        set_mode(2'b01);
        chk("R3 fei mon", {2'b0, ref_mon, osc_mon}, 4'h1);
        pulse_loss(1'b1, 1'b0);
        chk("R12 fei ref loss ignored", {3'b0, loss_stat}, 4'h0);
        pulse_loss(1'b0, 1'b1);
        chk("R11 fei lock reset wins", {loss_stat, lock_stat, irq, rst_req}, 4'hD);
        chk("R7 fei mode kept", {2'b0, mode_act}, 4'h1);
        do_reset();
        chk("R1 reset clears", {loss_stat, lock_stat, irq, rst_req}, 4'h0);
        ref_valid = 1'b1;
        set_mode(2'b10);
        pulse_loss(1'b1, 1'b0);
        chk("R11 byp loss irq with lol reset", {loss_stat, lock_stat, irq, rst_req}, 4'hA);
        ack();
        lol_reset_en = 1'b0;
    endtask

    task automatic t_rol();
        loc_reset_en = 1'b1;
        set_mode(2'b11);
        pulse_loss(1'b0, 1'b1);
        chk("R10 reset request", {loss_stat, 1'b0, irq, rst_req}, 4'h9);
        ack();
        chk("R10 ack ignored", {3'b0, loss_stat}, 4'h1);
        do_reset();
        chk("R10 reset clears", {loss_stat, 1'b0, irq, rst_req}, 4'h0);
        loc_reset_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_mode_write();
        t_fee_osc();
        t_byp_ref();
        t_fee_ref();
        t_disable();
        t_fb_vs_write();
        t_fei();
        t_rol();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule